// File: doc/BRIEF.md
# Modem handshake status and interrupt logic

This block is the modem-control slice of one serial controller channel. It watches three incoming handshake lines: clear-to-send, data-set-ready and carrier-detect. For each line it keeps a live level bit and a sticky transition flag. Each line arms its flag on its own edge and under its own condition. Carrier-detect and clear-to-send flag on going inactive, and data-set-ready flags on becoming active. A per-source interrupt request is raised while a flag is set and its enable bit is on.

Software reaches three byte-wide registers over a simple synchronous bus: a status register, a control register and an interrupt-enable register. The control register drives the request-to-send and data-terminal-ready outputs. Both outputs are active low and idle high. Request-to-send acts as a latch. Once software raises it, only a transmit completion with an empty transmit FIFO can drop it. That completion also clears the control bit that raised it. The transmitter enable and receiver reset inputs come from the neighbouring transmitter and receiver and gate the flags.

Top module: `modem_hs_ctl`

## Requirements
- R1: After reset, all three registers read 0x00 when the handshake inputs are low. rts_n and dtr_n are 1, and every irq output is 0.
- R2: Status bit 4 tracks the synchronized clear-to-send level. On a 1-to-0 change, status bit 7 sets only if the level was 1, control bit 7 is 1 and tx_en is 1. A 0-to-1 change only sets bit 4.
- R3: Status bit 3 tracks the data-set-ready level. On a 0-to-1 change, status bit 6 sets only if rx_rst is 0. A 1-to-0 change only clears bit 3.
- R4: Status bit 2 tracks the carrier-detect level. On a 1-to-0 change, status bit 5 sets only if rx_rst is 0. A 0-to-1 change only sets bit 2.
- R5: irq_cts is status bit 7 AND enable bit 7, irq_dsr is bit 6 AND enable bit 6, and irq_dcd is bit 5 AND enable bit 5. A request stays asserted until its flag is cleared or its enable bit is turned off.
- R6: A write to status address 0x10 clears each of bits 7..5 that is written as 1. Level bits are unaffected. If a new transition arrives in the same cycle as its clear, the flag ends set.
- R7: A write to control address 0x11 that changes bit 7 from 0 to 1 drives rts_n to 0. rts_n stays 0 even if bit 7 is later written to 0. A tx_done_empty pulse returns rts_n to 1 and clears control bit 7.
- R8: dtr_n equals the inverse of control bit 6 from the cycle after each control write. Control bits read back as written.
- R9: A handshake input change appears in the status register on the third rising clock edge after it, and not on the second.
- R10: Status bits 1..0 and enable bits 4..0 read 0. The enable register is at address 0x15. All other addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| cts_in | input | 1 | Clear-to-send, 1 = active, asynchronous |
| dsr_in | input | 1 | Data-set-ready, 1 = active, asynchronous |
| dcd_in | input | 1 | Carrier-detect, 1 = active, asynchronous |
| tx_en | input | 1 | Transmitter enabled |
| rx_rst | input | 1 | Receiver held in reset |
| tx_done_empty | input | 1 | Transmit completed with empty FIFO (pulse) |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| irq_cts | output | 1 | Clear-to-send interrupt request |
| irq_dsr | output | 1 | Data-set-ready interrupt request |
| irq_dcd | output | 1 | Carrier-detect interrupt request |

## Verification
The hardest case is a flag clear written in the very cycle a new transition is detected. That cycle lies two synchronizer stages behind the input change. The stimulus changes carrier-detect just after a falling clock edge, counts two rising edges, and then strobes the clearing write so that it lands on the detection edge. Random phases hold the gating inputs steady across each input change. A bench model then predicts every flag and request.

// File: rtl/modem_hs_ctl.sv
module modem_hs_ctl #(
  parameter int AW = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] STAT_ADDR = 5'h10,
  parameter logic [AW-1:0] CTRL_ADDR = 5'h11,
  parameter logic [AW-1:0] IEN_ADDR  = 5'h15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          cts_in,
  input  logic          dsr_in,
  input  logic          dcd_in,
  input  logic          tx_en,
  input  logic          rx_rst,
  input  logic          tx_done_empty,
  output logic          rts_n,
  output logic          dtr_n,
  output logic          irq_cts,
  output logic          irq_dsr,
  output logic          irq_dcd
);
  localparam int CW = SYNC_STAGES * 3;

  logic [CW-1:0] chain;
  logic [2:0]    syn, lvl, flag, hit, clr, ien_q;
  logic [7:0]    ctrl_q;
  logic          rts_act;

  wire stat_wr = wr_en && addr == STAT_ADDR;
  wire ctrl_wr = wr_en && addr == CTRL_ADDR;
  wire ien_wr  = wr_en && addr == IEN_ADDR;

  assign syn = chain[CW-1 -: 3];
  assign hit[2] = lvl[2] & ~syn[2] & ctrl_q[7] & tx_en;
  assign hit[1] = ~lvl[1] & syn[1] & ~rx_rst;
  assign hit[0] = lvl[0] & ~syn[0] & ~rx_rst;
  assign clr = stat_wr ? wdata[7:5] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      lvl   <= '0;
      flag  <= '0;
    end else begin
      chain <= {chain[CW-4:0], cts_in, dsr_in, dcd_in};
      lvl   <= syn;
      flag  <= (flag & ~clr) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      rts_act <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (tx_done_empty) ctrl_q[7] <= 1'b0;
      if (ien_wr) ien_q <= wdata[7:5];
      if (tx_done_empty) rts_act <= 1'b0;
      else if (ctrl_wr && wdata[7] && !ctrl_q[7]) rts_act <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      STAT_ADDR: rdata = {flag, lvl, 2'b00};
      CTRL_ADDR: rdata = ctrl_q;
      IEN_ADDR:  rdata = {ien_q, 5'b00000};
      default:   rdata = 8'h00;
    endcase
  end

  assign rts_n   = ~rts_act;
  assign dtr_n   = ~ctrl_q[6];
  assign irq_cts = flag[2] & ien_q[2];
  assign irq_dsr = flag[1] & ien_q[1];
  assign irq_dcd = flag[0] & ien_q[0];

  assert_cts_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[2]) |-> ($past(lvl[2]) && !lvl[2] && $past(ctrl_q[7]) && $past(tx_en)));
  assert_dsr_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[1]) |-> (!$past(lvl[1]) && lvl[1] && !$past(rx_rst)));
  assert_dcd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> ($past(lvl[0]) && !lvl[0] && !$past(rx_rst)));
  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_dcd && !stat_wr && !ien_wr) |=> irq_dcd);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[2] && !stat_wr) |=> flag[2]);
  assert_rts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_n && !tx_done_empty) |=> !rts_n);
  assert_rts_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_empty |=> (rts_n && !ctrl_q[7]));
  assert_dtr_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (dtr_n == !$past(wdata[6])));
endmodule

// File: tb/modem_hs_ctl_bench.sv
module modem_hs_ctl_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic cts_in = 0, dsr_in = 0, dcd_in = 0, tx_en = 0, rx_rst = 0, tx_done_empty = 0;
  logic rts_n, dtr_n, irq_cts, irq_dsr, irq_dcd;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  modem_hs_ctl u_modem_hs_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .tx_en(tx_en), .rx_rst(rx_rst),
    .tx_done_empty(tx_done_empty), .rts_n(rts_n), .dtr_n(dtr_n),
    .irq_cts(irq_cts), .irq_dsr(irq_dsr), .irq_dcd(irq_dcd));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string tag, logic [4:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done_empty = 1;
    @(negedge clk); tx_done_empty = 0;
  endtask

  function automatic logic [2:0] flag_sets(logic [2:0] lo, logic [2:0] ni,
                                           logic rb, logic te, logic rr);
    return {lo[2] & ~ni[2] & rb & te, ~lo[1] & ni[1] & ~rr, lo[0] & ~ni[0] & ~rr};
  endfunction

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] m_lvl, m_flag, m_ien, ni;
    logic rb, te, rr;
    logic [7:0] mask;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 rts_n", {7'd0, rts_n}, 8'h01);
    chk("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
    chk("R1 irqs", {5'd0, irq_cts, irq_dsr, irq_dcd}, 8'h00);
    rd("R1 status", 5'h10, 8'h00);
    rd("R1 ctrl", 5'h11, 8'h00);
    rd("R1 ien", 5'h15, 8'h00);

    wr(5'h15, 8'hFF);
    rd("R10 ien pad", 5'h15, 8'hE0);
    rd("R10 unmapped", 5'h00, 8'h00);
    wr(5'h15, 8'h00);

    wr(5'h11, 8'h40);
    #1 chk("R8 dtr low", {7'd0, dtr_n}, 8'h00);
    rd("R8 ctrl readback", 5'h11, 8'h40);
    wr(5'h11, 8'h00);
    #1 chk("R8 dtr high", {7'd0, dtr_n}, 8'h01);

    wr(5'h15, 8'h40);
    @(negedge clk); addr = 5'h10; dsr_in = 1;
    repeat (2) @(posedge clk); #1;
    chk("R9 not yet", rdata, 8'h00);
    @(posedge clk); #1;
    chk("R9 third edge / R3 rise", rdata, 8'h48);
    chk("R5 irq_dsr", {7'd0, irq_dsr}, 8'h01);
    wr(5'h10, 8'h40);
    rd("R6 clear keeps level", 5'h10, 8'h08);
    #1 chk("R5 irq_dsr cleared", {7'd0, irq_dsr}, 8'h00);
    @(negedge clk); dsr_in = 0; settle();
    rd("R3 fall level only", 5'h10, 8'h00);
    @(negedge clk); rx_rst = 1; dsr_in = 1; settle();
    rd("R3 gated by rx_rst", 5'h10, 8'h08);
    @(negedge clk); dsr_in = 0; rx_rst = 0; settle();

    @(negedge clk); dcd_in = 1; settle();
    rd("R4 rise level only", 5'h10, 8'h04);
    @(negedge clk); dcd_in = 0; settle();
    rd("R4 fall flag", 5'h10, 8'h20);
    wr(5'h10, 8'hE0);
    @(negedge clk); dcd_in = 1; settle();
    @(negedge clk); rx_rst = 1; dcd_in = 0; settle();
    rd("R4 gated by rx_rst", 5'h10, 8'h00);
    @(negedge clk); rx_rst = 0;

    @(negedge clk); cts_in = 1; settle();
    rd("R2 rise level only", 5'h10, 8'h10);
    @(negedge clk); tx_en = 1; cts_in = 0; settle();
    rd("R2 gated by rts bit", 5'h10, 8'h00);
    wr(5'h11, 8'h80);
    #1 chk("R7 rts asserted", {7'd0, rts_n}, 8'h00);
    wr(5'h15, 8'h80);
    @(negedge clk); cts_in = 1; settle();
    @(negedge clk); cts_in = 0; settle();
    rd("R2 fall flag", 5'h10, 8'h80);
    #1 chk("R5 irq_cts", {7'd0, irq_cts}, 8'h01);
    wr(5'h10, 8'h80);
    @(negedge clk); tx_en = 0; cts_in = 1; settle();
    @(negedge clk); cts_in = 0; settle();
    rd("R2 gated by tx_en", 5'h10, 8'h00);

    wr(5'h11, 8'h00);
    #1 chk("R7 rts held", {7'd0, rts_n}, 8'h00);
    pulse_done();
    #1 chk("R7 rts released", {7'd0, rts_n}, 8'h01);
    wr(5'h11, 8'h80);
    #1 chk("R7 rts again", {7'd0, rts_n}, 8'h00);
    pulse_done();
    #1 chk("R7 rts released 2", {7'd0, rts_n}, 8'h01);
    rd("R7 ctrl bit cleared", 5'h11, 8'h00);

    @(negedge clk); dcd_in = 1; settle();
    @(negedge clk); dcd_in = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 5'h10; wdata = 8'h20; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd("R6 set wins", 5'h10, 8'h20);
    wr(5'h10, 8'hE0);
    rd("R6 cleared", 5'h10, 8'h00);

    m_lvl = 3'b000; m_flag = 3'b000;
    for (int i = 0; i < 200; i++) begin
      rb = 1'($urandom); te = 1'($urandom); rr = 1'($urandom);
      m_ien = 3'($urandom);
      wr(5'h11, {rb, 7'd0});
      wr(5'h15, {m_ien, 5'd0});
      @(negedge clk); tx_en = te; rx_rst = rr;
      ni = 3'($urandom);
      @(negedge clk); {cts_in, dsr_in, dcd_in} = ni;
      settle();
      m_flag = m_flag | flag_sets(m_lvl, ni, rb, te, rr);
      m_lvl = ni;
      rd("R2 R3 R4 random status", 5'h10, {m_flag, m_lvl, 2'b00});
      chk("R5 random irqs", {5'd0, irq_cts, irq_dsr, irq_dcd}, {5'd0, m_flag & m_ien});
      if ($urandom % 3 == 0) begin
        mask = 8'($urandom);
        wr(5'h10, mask);
        m_flag = m_flag & ~mask[7:5];
        rd("R6 random clear", 5'h10, {m_flag, m_lvl, 2'b00});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule